// File: doc/BRIEF.md
# Burst-8 Write Splitter and Data Masker

This block turns one incrementing or single write request into the command and per-beat control stream of an SDRAM whose burst length is fixed at eight. A request gives a start column and a beat count. The column's upper bits pick an aligned group of eight columns. Its lowest three bits give the starting position inside that group. Inside one burst the device wraps the column within the group. To keep the data from wrapping, the block splits the transfer so that each WRITE runs only up to the end of its group. When more data remains, the next WRITE starts at offset zero of the following group.

Each burst moves a fixed eight beats. Beats beyond the requested data must not reach the array, and the block handles them in one of two ways, selected per request. In DDR mode every burst keeps all eight slots active so the strobe keeps toggling, and the surplus slots are masked. In SDR mode the data starts in the same cycle as the command. The unused tail is then cut with a BURST STOP. Row management, timing gaps between commands and the physical data path are handled elsewhere.

Top module: `wb8_write_split`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, cmd_wr_o, cmd_bst_o, beat_act_o, beat_use_o and beat_dm_o are 0. cmd_col_o and beat_col_o are 0 whenever their strobe is low.
- R2: A request (req_i high) is accepted only in a cycle where busy_o is 0, and busy_o is 1 from the next cycle on. A request raised while busy_o is 1 is ignored and leaves the command and beat stream unchanged.
- R3: Each WRITE covers n = min(8 - start[2:0], remaining) beats. If beats remain, the next WRITE carries the column of the next 8-column group with start[2:0] = 0, and the group index wraps at the top of the column range.
- R4: Beat slot k of a WRITE at column c reports beat_col_o = {c[COL_W-1:3], (c[2:0] + k) mod 8}.
- R5: req_len_i encodes the beat count: 0 gives 1 beat, 1 gives 4, 2 gives 8 and 3 gives 16.
- R6: In DDR mode (ddr_i = 1), a WRITE in cycle t is followed by eight active slots (beat_act_o = 1) in cycles t+1 to t+8. A following WRITE is issued in cycle t+8, together with slot 7.
- R7: In DDR mode the first n slots of a burst have beat_use_o = 1 and beat_dm_o = 0. The remaining slots have beat_use_o = 0 and beat_dm_o = 1.
- R8: In SDR mode (ddr_i = 0), a WRITE in cycle t carries slot 0 in the same cycle, and slots 0 to n-1 are active with beat_dm_o = 0. If n < 8, cmd_bst_o is high in cycle t+n and any next WRITE comes in cycle t+n+1. If n = 8, the next WRITE comes in cycle t+8 with no BURST STOP.
- R9: busy_o falls in the cycle after the last slot (DDR) or after the last slot or BURST STOP (SDR) of the final WRITE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request, taken when idle |
| req_col_i | input | COL_W | Start column; bits [2:0] are the offset within the group |
| req_len_i | input | 2 | Beat-count code |
| ddr_i | input | 1 | 1 selects DDR masking, 0 selects SDR burst stop |
| busy_o | output | 1 | A transfer is in progress |
| cmd_wr_o | output | 1 | Issue a WRITE command this cycle |
| cmd_col_o | output | COL_W | Column of the WRITE |
| cmd_bst_o | output | 1 | Issue a BURST STOP this cycle |
| beat_act_o | output | 1 | A data slot of a burst occupies this cycle |
| beat_use_o | output | 1 | The slot carries requested data |
| beat_dm_o | output | 1 | Data-mask level for the slot |
| beat_col_o | output | COL_W | Column written by the slot |

## Verification
Two functions can fall in the same cycle. In DDR mode a split transfer issues its next WRITE in the cycle that also carries slot 7 of the previous burst, and that slot is often masked. In SDR mode every WRITE shares its cycle with the first data slot. The bench provokes both overlaps with start offsets that cross a group and with 16-beat requests, in both modes. A cycle-accurate model builds the expected timeline independently and compares every output field on every clock. This shows that the new command column and the old slot's mask and column appear together and are each correct.

// File: rtl/wb8_pkg.sv
`timescale 1ns/1ps
package wb8_pkg;
  localparam int REM_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_BEAT = 2'd2,
    ST_STOP = 2'd3
  } wb8_st_e;

  function automatic logic [REM_W-1:0] len_beats(input logic [1:0] code);
    case (code)
      2'd0:    len_beats = 5'd1;
      2'd1:    len_beats = 5'd4;
      2'd2:    len_beats = 5'd8;
      default: len_beats = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/wb8_chunk.sv
`timescale 1ns/1ps
module wb8_chunk #(
  parameter int COL_W = 14
) (
  input  logic [COL_W-1:0]        col_i,
  input  logic [wb8_pkg::REM_W-1:0] rem_i,
  input  logic [2:0]              slot_i,
  output logic [3:0]              n_o,
  output logic                    more_o,
  output logic [COL_W-1:0]        next_col_o,
  output logic [COL_W-1:0]        slot_col_o
);
  localparam int GRP_W = COL_W - 3;

  logic [3:0] room;
  logic [2:0] slot_off;

  assign room = 4'd8 - {1'b0, col_i[2:0]};

  always_comb begin
    if (rem_i < {1'b0, room}) n_o = rem_i[3:0];
    else                      n_o = room;
  end

  assign more_o     = rem_i > {1'b0, n_o};
  assign next_col_o = {col_i[COL_W-1:3] + {{(GRP_W-1){1'b0}}, 1'b1}, 3'b000};
  assign slot_off   = col_i[2:0] + slot_i;
  assign slot_col_o = {col_i[COL_W-1:3], slot_off};
endmodule

// File: rtl/wb8_seq.sv
`timescale 1ns/1ps
module wb8_seq
  import wb8_pkg::*;
#(
  parameter int COL_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic [1:0]       req_len_i,
  input  logic             ddr_i,
  input  logic [3:0]       n_i,
  input  logic             more_i,
  input  logic [COL_W-1:0] next_col_i,
  output wb8_st_e          st_o,
  output logic             ddr_o,
  output logic [COL_W-1:0] col_o,
  output logic [REM_W-1:0] rem_o,
  output logic [2:0]       slot_o
);
  wb8_st_e          st_q;
  logic             ddr_q;
  logic [COL_W-1:0] col_q;
  logic [REM_W-1:0] rem_q;
  logic [2:0]       slot_q;
  logic             last_slot;

  // last data-carrying slot of the current chunk
  assign last_slot = ddr_q ? (slot_q == 3'd7)
                           : ({1'b0, slot_q} == (n_i - 4'd1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ddr_q  <= 1'b0;
      col_q  <= '0;
      rem_q  <= '0;
      slot_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_i) begin
          col_q  <= req_col_i;
          rem_q  <= len_beats(req_len_i);
          ddr_q  <= ddr_i;
          slot_q <= '0;
          st_q   <= ddr_i ? ST_CMD : ST_BEAT;
        end
        ST_CMD: begin
          slot_q <= '0;
          st_q   <= ST_BEAT;
        end
        ST_BEAT: begin
          if (!last_slot) begin
            slot_q <= slot_q + 3'd1;
          end else if (!ddr_q && n_i != 4'd8) begin
            st_q <= ST_STOP;
          end else if (more_i) begin
            col_q  <= next_col_i;
            rem_q  <= rem_q - {1'b0, n_i};
            slot_q <= '0;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        default: begin
          if (more_i) begin
            col_q  <= next_col_i;
            rem_q  <= rem_q - {1'b0, n_i};
            slot_q <= '0;
            st_q   <= ST_BEAT;
          end else begin
            st_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign st_o   = st_q;
  assign ddr_o  = ddr_q;
  assign col_o  = col_q;
  assign rem_o  = rem_q;
  assign slot_o = slot_q;

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && req_i) |=> (st_q != ST_IDLE));

  assert_mode_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && req_i) |=> $stable(ddr_q));

  assert_chunk_align_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> ($stable(col_q) || col_q[2:0] == 3'b000));

  assert_rem_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> (rem_q <= $past(rem_q)));
endmodule

// File: rtl/wb8_beat_out.sv
`timescale 1ns/1ps
module wb8_beat_out
  import wb8_pkg::*;
#(
  parameter int COL_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  wb8_st_e          st_i,
  input  logic             ddr_i,
  input  logic [2:0]       slot_i,
  input  logic [3:0]       n_i,
  input  logic             more_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] next_col_i,
  input  logic [COL_W-1:0] slot_col_i,
  output logic             busy_o,
  output logic             cmd_wr_o,
  output logic [COL_W-1:0] cmd_col_o,
  output logic             cmd_bst_o,
  output logic             beat_act_o,
  output logic             beat_use_o,
  output logic             beat_dm_o,
  output logic [COL_W-1:0] beat_col_o
);
  logic in_beat, use_w;

  assign busy_o    = (st_i != ST_IDLE);
  assign in_beat   = (st_i == ST_BEAT);
  assign use_w     = in_beat && ({1'b0, slot_i} < n_i);
  assign beat_use_o = use_w;
  assign beat_act_o = in_beat && (ddr_i || use_w);
  assign beat_dm_o  = in_beat && ddr_i && !use_w;
  assign beat_col_o = beat_act_o ? slot_col_i : '0;
  assign cmd_bst_o  = (st_i == ST_STOP);

  always_comb begin
    cmd_wr_o  = 1'b0;
    cmd_col_o = '0;
    if (st_i == ST_CMD) begin
      cmd_wr_o  = 1'b1;
      cmd_col_o = col_i;
    end else if (in_beat && !ddr_i && slot_i == 3'd0) begin
      cmd_wr_o  = 1'b1;
      cmd_col_o = col_i;
    end else if (in_beat && ddr_i && slot_i == 3'd7 && more_i) begin
      // next WRITE overlaps the final slot of the previous burst
      cmd_wr_o  = 1'b1;
      cmd_col_o = next_col_i;
    end
  end

  assert_dm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_dm_o |-> (beat_act_o && !beat_use_o && ddr_i));

  assert_bst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_bst_o |-> (!ddr_i && !beat_act_o && !cmd_wr_o));

  assert_sdr_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_o && !ddr_i) |-> beat_use_o);

  assert_ddr_lead_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_o && ddr_i && !beat_act_o) |=> (beat_act_o && beat_col_o == $past(cmd_col_o)));

  assert_bst_after_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_bst_o |=> (cmd_wr_o || !busy_o));
endmodule

// File: rtl/wb8_write_split.sv
`timescale 1ns/1ps
module wb8_write_split
  import wb8_pkg::*;
#(
  parameter int COL_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic [1:0]       req_len_i,
  input  logic             ddr_i,
  output logic             busy_o,
  output logic             cmd_wr_o,
  output logic [COL_W-1:0] cmd_col_o,
  output logic             cmd_bst_o,
  output logic             beat_act_o,
  output logic             beat_use_o,
  output logic             beat_dm_o,
  output logic [COL_W-1:0] beat_col_o
);
  wb8_st_e          st;
  logic             ddr_q;
  logic [COL_W-1:0] col_q, next_col, slot_col;
  logic [REM_W-1:0] rem_q;
  logic [2:0]       slot_q;
  logic [3:0]       n;
  logic             more;

  wb8_chunk #(.COL_W(COL_W)) u_chunk (
    .col_i      (col_q),
    .rem_i      (rem_q),
    .slot_i     (slot_q),
    .n_o        (n),
    .more_o     (more),
    .next_col_o (next_col),
    .slot_col_o (slot_col)
  );

  wb8_seq #(.COL_W(COL_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .req_col_i  (req_col_i),
    .req_len_i  (req_len_i),
    .ddr_i      (ddr_i),
    .n_i        (n),
    .more_i     (more),
    .next_col_i (next_col),
    .st_o       (st),
    .ddr_o      (ddr_q),
    .col_o      (col_q),
    .rem_o      (rem_q),
    .slot_o     (slot_q)
  );

  wb8_beat_out #(.COL_W(COL_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .st_i       (st),
    .ddr_i      (ddr_q),
    .slot_i     (slot_q),
    .n_i        (n),
    .more_i     (more),
    .col_i      (col_q),
    .next_col_i (next_col),
    .slot_col_i (slot_col),
    .busy_o     (busy_o),
    .cmd_wr_o   (cmd_wr_o),
    .cmd_col_o  (cmd_col_o),
    .cmd_bst_o  (cmd_bst_o),
    .beat_act_o (beat_act_o),
    .beat_use_o (beat_use_o),
    .beat_dm_o  (beat_dm_o),
    .beat_col_o (beat_col_o)
  );
endmodule

// File: tb/sim_wb8_write_split.sv
`timescale 1ns/1ps
module sim_wb8_write_split;
  localparam int COL_W = 14;
  localparam int COL_N = 1 << COL_W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_ni, req_i, ddr_i;
  logic [COL_W-1:0] req_col_i;
  logic [1:0]       req_len_i;
  logic             busy_o, cmd_wr_o, cmd_bst_o, beat_act_o, beat_use_o, beat_dm_o;
  logic [COL_W-1:0] cmd_col_o, beat_col_o;

  wb8_write_split #(.COL_W(COL_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_col_i(req_col_i),
    .req_len_i(req_len_i), .ddr_i(ddr_i), .busy_o(busy_o), .cmd_wr_o(cmd_wr_o),
    .cmd_col_o(cmd_col_o), .cmd_bst_o(cmd_bst_o), .beat_act_o(beat_act_o),
    .beat_use_o(beat_use_o), .beat_dm_o(beat_dm_o), .beat_col_o(beat_col_o)
  );

  typedef struct {
    bit cmd; int ccol; bit bst; bit act; bit use_; bit dm; int bcol;
  } rec_t;

  rec_t expq[$];
  int total = 0, bad = 0, cyc = 0;

  task automatic chk(input string tag, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, actual, expected, cyc);
    end
  endtask

  function automatic int beats_of(input int code); // R5 length codes
    case (code)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic build(input int col, input int lc, input bit ddr);
    rec_t tl[64];
    int rem, c, t, n, room, len;
    for (int i = 0; i < 64; i++) tl[i] = '{default: 0};
    rem = beats_of(lc); c = col; t = 0; len = 0;
    while (rem > 0) begin
      room = 8 - (c % 8);
      n = (rem < room) ? rem : room;
      tl[t].cmd = 1; tl[t].ccol = c;
      if (ddr) begin
        for (int k = 0; k < 8; k++) begin
          tl[t+1+k].act  = 1;
          tl[t+1+k].use_ = (k < n);
          tl[t+1+k].dm   = (k >= n);
          tl[t+1+k].bcol = (c / 8) * 8 + ((c % 8) + k) % 8;
        end
        rem -= n;
        if (rem > 0) t += 8; else len = t + 9;
      end else begin
        for (int k = 0; k < n; k++) begin
          tl[t+k].act  = 1;
          tl[t+k].use_ = 1;
          tl[t+k].bcol = (c / 8) * 8 + ((c % 8) + k) % 8;
        end
        t += n;
        if (n < 8) begin tl[t].bst = 1; t++; end
        rem -= n;
        len = t;
      end
      c = ((c / 8 + 1) * 8) % COL_N;
    end
    for (int i = 0; i < len; i++) expq.push_back(tl[i]);
  endtask

  task automatic step(input bit rq, input int col, input int lc, input bit ddr);
    rec_t e;
    bit eb;
    @(negedge clk);
    if (expq.size() > 0) begin e = expq.pop_front(); eb = 1; end
    else begin e = '{default: 0}; eb = 0; end
    chk("R9 busy_o", busy_o, eb);
    chk("R3 cmd_wr_o", cmd_wr_o, e.cmd);
    chk("R3 cmd_col_o", cmd_col_o, e.ccol);
    chk("R8 cmd_bst_o", cmd_bst_o, e.bst);
    chk("R6 beat_act_o", beat_act_o, e.act);
    chk("R7 beat_use_o", beat_use_o, e.use_);
    chk("R7 beat_dm_o", beat_dm_o, e.dm);
    chk("R4 beat_col_o", beat_col_o, e.bcol);
    req_i     = rq;
    req_col_i = col[COL_W-1:0];
    req_len_i = lc[1:0];
    ddr_i     = ddr;
    if (rq && !eb) build(col, lc, ddr); // R2: ignored when busy
  endtask

  task automatic drain();
    while (expq.size() > 0) step(0, 0, 0, 0);
  endtask

  task automatic run(input int col, input int lc, input bit ddr);
    step(1, col, lc, ddr);
    drain();
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      bad++;
      $display("FAIL R9 watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    rst_ni = 1'b0; req_i = 1'b0; req_col_i = '0; req_len_i = '0; ddr_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1: idle outputs during reset
    chk("R1 busy_o", busy_o, 0);
    chk("R1 cmd_wr_o", cmd_wr_o, 0);
    chk("R1 cmd_bst_o", cmd_bst_o, 0);
    chk("R1 beat_act_o", beat_act_o, 0);
    chk("R1 beat_dm_o", beat_dm_o, 0);
    rst_ni = 1'b1;
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    for (int m = 1; m >= 0; m--) begin
      // R5: each length code in each mode
      run(0, 0, m[0]);
      run(5, 0, m[0]);
      run(0, 1, m[0]);
      run(6, 1, m[0]);
      run(4, 1, m[0]);
      run(0, 2, m[0]);
      run(3, 2, m[0]);
      run(2, 3, m[0]);
      run(0, 3, m[0]);
      run(7, 3, m[0]);
      run(COL_N - 2, 1, m[0]);
      run(COL_N - 1, 3, m[0]);
    end
    // R2: request while busy is ignored
    step(1, 10, 2, 1);
    step(0, 0, 0, 0);
    step(1, 3, 3, 0);
    step(1, 21, 0, 0);
    drain();
    step(1, 13, 1, 0);
    step(1, 40, 3, 1);
    drain();
    repeat (4) step(0, 0, 0, 0);
    finish_run();
  end
endmodule